// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower memory. It holds 8 KB as 256 lines of 32 bytes each and places every line at exactly one slot. A 34-bit byte address is split into three fields. Bits [4:0] are the offset inside the line, and within them bits [4:2] pick the 32-bit word. Bits [12:5] are the line index and bits [33:13] are the tag. On every access the block looks up the slot named by the index and compares the stored tag with the address tag. The slot must also hold a set valid bit for the access to count as a hit.

A load that hits returns its word on the cycle after it is accepted. A load that misses sends one block-aligned refill request. The memory returns eight 32-bit beats in ascending word order, starting at word 0, and the block writes each beat into the line. After the last beat it marks the line valid under the new tag and returns the requested word. Stores go out to a downstream write buffer in the same cycle they are accepted, so the processor does not wait for memory. If the store hits, only the byte lanes it enables are also merged into the cached line. A store that misses leaves the cache untouched, so lines never hold modified data. An invalidate input clears every valid bit in one cycle.

Top module: `dc_wt_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `rsp_valid`, `fill_req_valid` and `wb_valid` are 0.
- R2: The address fields are tag = [33:13], index = [12:5], word = [4:2]. A refill request carries the load address with bits [4:0] cleared.
- R3: A load miss issues exactly one refill request and consumes eight beats, each 32 bits. The beats fill words 0 to 7 of the line in order. The load then returns the word selected by address bits [4:2].
- R4: A load to a valid line with a matching tag raises `rsp_valid` for exactly one cycle, on the cycle after acceptance. It returns the cached word and issues no refill.
- R5: Two addresses with the same index and different tags evict each other. After the second is loaded, a load to the first misses again.
- R6: A store drives `wb_valid` with its address, data and byte enables unchanged, and is accepted in the same cycle the write buffer accepts it.
- R7: A store hit writes only the bytes whose enable bit is set into the line. Byte enable bit i covers data bits [8i+7:8i]. A later load to that word hits and returns the merged value.
- R8: A store miss does not allocate a line. A following load to the same line misses and returns the stored data from memory.
- R9: While `wb_ready` is 0, a store is not accepted and `req_ready` stays 0.
- R10: While `inval_all` is 1, no request is accepted. After it, every line is invalid, so a load to a previously cached line misses.
- R11: Once raised, a refill request keeps its address stable until `fill_req_ready` accepts it.
- R12: `rsp_valid` is raised only for an accepted load. On a miss it is raised only after the last refill beat, even when beats arrive with idle gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inval_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 34 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Load data |
| fill_req_valid | output | 1 | Refill request present |
| fill_req_ready | input | 1 | Memory accepts refill request |
| fill_req_addr | output | 34 | Block-aligned refill address |
| fill_beat_valid | input | 1 | Refill beat present |
| fill_beat_data | input | 32 | Refill beat data |
| wb_valid | output | 1 | Store offered to write buffer |
| wb_ready | input | 1 | Write buffer can take a store |
| wb_addr | output | 34 | Store address |
| wb_wdata | output | 32 | Store data |
| wb_be | output | 4 | Store byte enables |

## Verification
Loads are tried cold, to another word of a freshly filled line, and to a line just evicted by a conflicting tag. This separates correct hit detection from a cache that always misses or ignores the tag. Stores are tried with sparse byte enables to a resident line, then to an absent line followed by a load. This tells a correct byte merge apart from a whole-word write, and no-allocate apart from allocate. Refills are run back to back, with beat gaps and with a stalled request, to expose early responses and drifting refill addresses. A sweep of mixed addresses and an invalidate-all pass exercise the hit/miss model across many indices.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_FILL = 2'd2
   } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int LINES = 256,
   parameter int TAG_W = 21,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic [IDX_W-1:0] look_idx,
   input  logic [TAG_W-1:0] look_tag,
   output logic             hit,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [TAG_W-1:0] set_tag
);
   logic [LINES-1:0] vld_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld_q <= '0;
      else if (clr_all) vld_q <= '0;
      else if (set_en)  vld_q[set_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (set_en) tag_q[set_idx] <= set_tag;
   end

   assign hit = vld_q[look_idx] && (tag_q[look_idx] == look_tag);

   // R10
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (vld_q == '0));
   // R3
   fill_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_all) |=> vld_q[$past(set_idx)]);
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 2048,
   localparam int AW = $clog2(DEPTH),
   localparam int NB = WORD_W / 8
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [NB-1:0]     wr_be
);
   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [7:0] lane_q [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && wr_be[b]) lane_q[wr_addr] <= wr_data[8*b +: 8];
      end
      assign rd_data[8*b +: 8] = lane_q[rd_addr];
   end
endmodule

// File: rtl/dc_wt_cache.sv
module dc_wt_cache #(
   parameter int ADDR_W     = 34,
   parameter int LINE_BYTES = 32,
   parameter int LINES      = 256,
   parameter int WORD_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inval_all,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_we,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [WORD_W-1:0]     req_wdata,
   input  logic [WORD_W/8-1:0]   req_be,
   output logic                  rsp_valid,
   output logic [WORD_W-1:0]     rsp_rdata,
   output logic                  fill_req_valid,
   input  logic                  fill_req_ready,
   output logic [ADDR_W-1:0]     fill_req_addr,
   input  logic                  fill_beat_valid,
   input  logic [WORD_W-1:0]     fill_beat_data,
   output logic                  wb_valid,
   input  logic                  wb_ready,
   output logic [ADDR_W-1:0]     wb_addr,
   output logic [WORD_W-1:0]     wb_wdata,
   output logic [WORD_W/8-1:0]   wb_be
);
   import dc_pkg::*;

   localparam int WORD_BYTES = WORD_W / 8;
   localparam int BSEL_W     = $clog2(WORD_BYTES);
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int IDX_W      = $clog2(LINES);
   localparam int BEATS      = LINE_BYTES / WORD_BYTES;
   localparam int BEAT_W     = $clog2(BEATS);
   localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
   localparam int DEPTH      = LINES * BEATS;
   localparam int DA_W       = IDX_W + BEAT_W;
   localparam int MQ_W       = ADDR_W - BSEL_W;

   if ((WORD_W % 8) != 0 || (1 << BSEL_W) != WORD_BYTES) begin : g_bad_word
      $error("WORD_W must be a power-of-two number of bytes");
   end
   if ((1 << OFF_W) != LINE_BYTES || BEATS < 2) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding at least two words");
   end
   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for index and offset");
   end

   dc_state_e         state_q;
   logic [MQ_W-1:0]   miss_q;
   logic [BEAT_W-1:0] beat_q;

   logic [TAG_W-1:0]  a_tag, m_tag;
   logic [IDX_W-1:0]  a_idx, m_idx;
   logic [BEAT_W-1:0] a_word, m_word;
   logic idle, acc, rd_acc, wr_acc, hit, beat_in, last_beat;
   logic              ds_wr_en;
   logic [DA_W-1:0]   ds_wr_addr;
   logic [WORD_W-1:0] ds_wr_data, ds_rd_data;
   logic [WORD_BYTES-1:0] ds_wr_be;

   assign a_tag  = req_addr[ADDR_W-1 -: TAG_W];
   assign a_idx  = req_addr[OFF_W +: IDX_W];
   assign a_word = req_addr[BSEL_W +: BEAT_W];
   assign m_tag  = miss_q[MQ_W-1 -: TAG_W];
   assign m_idx  = miss_q[OFF_W-BSEL_W +: IDX_W];
   assign m_word = miss_q[0 +: BEAT_W];

   assign idle      = (state_q == ST_IDLE);
   assign req_ready = idle && !inval_all && (!req_we || wb_ready);
   assign acc       = req_valid && req_ready;
   assign rd_acc    = acc && !req_we;
   assign wr_acc    = acc && req_we;

   assign wb_valid  = req_valid && req_we && idle && !inval_all;
   assign wb_addr   = req_addr;
   assign wb_wdata  = req_wdata;
   assign wb_be     = req_be;

   assign fill_req_valid = (state_q == ST_REQ);
   assign fill_req_addr  = {miss_q[MQ_W-1:OFF_W-BSEL_W], {OFF_W{1'b0}}};
   assign beat_in        = (state_q == ST_FILL) && fill_beat_valid;
   assign last_beat      = beat_in && (beat_q == BEAT_W'(BEATS - 1));

   assign ds_wr_en   = beat_in || (wr_acc && hit);
   assign ds_wr_addr = beat_in ? {m_idx, beat_q} : {a_idx, a_word};
   assign ds_wr_data = beat_in ? fill_beat_data : req_wdata;
   assign ds_wr_be   = beat_in ? '1 : req_be;

   dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (inval_all),
      .look_idx (a_idx),
      .look_tag (a_tag),
      .hit      (hit),
      .set_en   (last_beat),
      .set_idx  (m_idx),
      .set_tag  (m_tag)
   );

   dc_data_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_data (
      .clk     (clk),
      .rd_addr ({a_idx, a_word}),
      .rd_data (ds_rd_data),
      .wr_en   (ds_wr_en),
      .wr_addr (ds_wr_addr),
      .wr_data (ds_wr_data),
      .wr_be   (ds_wr_be)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         miss_q    <= '0;
         beat_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (rd_acc) begin
                  if (hit) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= ds_rd_data;
                  end else begin
                     miss_q  <= req_addr[ADDR_W-1:BSEL_W];
                     state_q <= ST_REQ;
                  end
               end
            end
            ST_REQ: begin
               if (fill_req_ready) begin
                  state_q <= ST_FILL;
                  beat_q  <= '0;
               end
            end
            ST_FILL: begin
               if (beat_in) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == m_word) rsp_rdata <= fill_beat_data;
                  if (last_beat) begin
                     rsp_valid <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R11
   fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));
   // R2
   fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && !hit) |=> (fill_req_valid &&
         fill_req_addr == {$past(req_addr[ADDR_W-1:OFF_W]), {OFF_W{1'b0}}}));
   // R4
   hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && hit) |=> rsp_valid);
   // R12
   no_early_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> !rsp_valid);
   // R6
   wb_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_ready) |-> req_ready);
   // R7
   port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_in |-> !wr_acc);
endmodule

// File: tb/dc_wt_cache_tb.sv
module dc_wt_cache_tb;
   logic clk = 0;
   logic rst_n = 0;
   logic inval_all = 0;
   logic req_valid = 0, req_we = 0;
   logic [33:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   logic fill_req_valid;
   logic fill_req_ready = 1;
   logic [33:0] fill_req_addr;
   logic fill_beat_valid = 0;
   logic [31:0] fill_beat_data = '0;
   logic wb_valid;
   logic wb_ready = 1;
   logic [33:0] wb_addr;
   logic [31:0] wb_wdata;
   logic [3:0]  wb_be;

   always #2 clk = ~clk;

   dc_wt_cache u_dut (
      .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
      .fill_req_addr(fill_req_addr),
      .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
      .wb_wdata(wb_wdata), .wb_be(wb_be)
   );

   int total = 0, bad = 0;
   logic [7:0] bmem [logic [33:0]];
   bit mv [256];
   logic [20:0] mt [256];
   int fill_cnt = 0, fill_left = 0, stall_left = 0;
   bit gap_mode = 0, gap_t = 0;
   logic [33:0] fill_base, exp_fill_addr;
   bit rsp_exp = 0, st_pend = 0, st_pushed = 0;
   logic [33:0] st_addr; logic [31:0] st_data; logic [3:0] st_be;
   bit prev_hold = 0; logic [33:0] prev_faddr;

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_word(input logic [33:0] a);
      logic [31:0] w;
      for (int i = 0; i < 4; i++) begin
         logic [33:0] k;
         k = {a[33:2], 2'(i)};
         if (bmem.exists(k)) w[8*i +: 8] = bmem[k];
         else w[8*i +: 8] = k[7:0] ^ k[17:10] ^ k[27:20] ^ 8'h3C;
      end
      return w;
   endfunction

   // memory side: refill responder
   initial forever begin
      @(negedge clk);
      fill_beat_valid = 0;
      if (fill_req_valid && stall_left > 0) begin
         fill_req_ready = 0;
         stall_left--;
      end else fill_req_ready = 1;
      if (fill_left > 0) begin
         if (gap_mode && gap_t) gap_t = 0;
         else begin
            fill_beat_valid = 1;
            fill_beat_data = rd_word(fill_base + 34'(4 * (8 - fill_left)));
            fill_left--;
            gap_t = 1;
         end
      end else if (fill_req_valid && fill_req_ready) begin
         chk(fill_req_addr == exp_fill_addr, "R2 refill address aligned", fill_req_addr, exp_fill_addr);
         fill_base = fill_req_addr;
         fill_left = 8;
         fill_cnt++;
      end
   end

   // per-clock monitor
   initial forever begin
      @(negedge clk); #1;
      if (rst_n) begin
         if (prev_hold) chk(fill_req_valid && fill_req_addr == prev_faddr,
                            "R11 refill request held", fill_req_addr, prev_faddr);
         prev_hold = fill_req_valid && !fill_req_ready;
         prev_faddr = fill_req_addr;
         if (rsp_valid) chk(rsp_exp, "R12 response only for accepted load", rsp_valid, rsp_exp);
         if (wb_valid && wb_ready) begin
            chk(st_pend && !st_pushed, "R6 unexpected write-buffer push", 1, st_pend);
            chk(wb_addr == st_addr && wb_wdata == st_data && wb_be == st_be,
                "R6 write-buffer fields", {wb_be, wb_wdata}, {st_be, st_data});
            for (int i = 0; i < 4; i++)
               if (wb_be[i]) bmem[{wb_addr[33:2], 2'(i)}] = wb_wdata[8*i +: 8];
            st_pushed = 1;
         end
      end
   end

   task automatic do_read(input logic [33:0] a);
      logic [7:0] idx; logic [20:0] tg; bit eh; logic [31:0] ed; int f0, lat;
      idx = a[12:5]; tg = a[33:13];
      eh = mv[idx] && mt[idx] == tg;
      ed = rd_word(a);
      f0 = fill_cnt;
      exp_fill_addr = {a[33:5], 5'b0};
      @(negedge clk);
      req_valid = 1; req_we = 0; req_addr = a;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      rsp_exp = 1;
      @(negedge clk);
      req_valid = 0;
      lat = 1;
      while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
      chk(rsp_valid, "R3 load response arrives", rsp_valid, 1);
      chk(rsp_rdata == ed, eh ? "R4 hit data" : "R3 miss data", rsp_rdata, ed);
      chk(fill_cnt - f0 == (eh ? 0 : 1), eh ? "R4 hit makes no refill" : "R5 miss makes one refill",
          fill_cnt - f0, eh ? 0 : 1);
      if (eh) chk(lat == 1, "R4 hit latency", lat, 1);
      else chk(lat >= 10 && fill_left == 0, "R12 response after last beat", lat, 10);
      @(negedge clk);
      chk(!rsp_valid, "R4 single-cycle response", rsp_valid, 0);
      rsp_exp = 0;
      mv[idx] = 1; mt[idx] = tg;
   endtask

   task automatic do_write(input logic [33:0] a, input logic [31:0] d, input logic [3:0] be);
      st_addr = a; st_data = d; st_be = be; st_pend = 1; st_pushed = 0;
      @(negedge clk);
      req_valid = 1; req_we = 1; req_addr = a; req_wdata = d; req_be = be;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      req_valid = 0; req_we = 0;
      chk(st_pushed, "R6 store forwarded", st_pushed, 1);
      st_pend = 0;
   endtask

   localparam logic [33:0] A0 = 34'h2_468A_C0E4;
   localparam logic [33:0] B0 = 34'h1_1357_9B48;
   localparam logic [33:0] C0 = 34'h0_FEDC_BA70;

   initial begin
      for (int i = 0; i < 256; i++) mv[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      chk(req_ready && !rsp_valid && !fill_req_valid && !wb_valid, "R1 reset state",
          {req_ready, rsp_valid, fill_req_valid, wb_valid}, 4'b1000);

      do_read(A0);                            // R3 cold miss
      do_read(A0 ^ 34'h1C);                   // R4 other word same line hits
      do_read(A0 ^ 34'h1_0000_0000);          // R5 conflicting tag
      do_read(A0);                            // R5 evicted line misses again
      do_write(A0, 32'hDEAD_BEEF, 4'b0101);   // R7 store hit, sparse bytes
      do_read(A0);                            // R7 merged data on hit
      do_write(B0, 32'h1234_5678, 4'b1111);   // R8 store miss
      do_read(B0);                            // R8 no allocate: misses

      // R9 write buffer full
      wb_ready = 0;
      st_addr = C0; st_data = 32'hA5A5_0001; st_be = 4'b0011; st_pend = 1; st_pushed = 0;
      @(negedge clk);
      req_valid = 1; req_we = 1; req_addr = C0; req_wdata = 32'hA5A5_0001; req_be = 4'b0011;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk(!req_ready && !st_pushed, "R9 store held while buffer full", req_ready, 0);
      end
      wb_ready = 1;
      @(negedge clk); #1;
      req_valid = 0; req_we = 0;
      @(negedge clk);
      chk(st_pushed, "R9 store accepted after buffer frees", st_pushed, 1);
      st_pend = 0;

      // R11 / R12 stalled request and gapped beats
      gap_mode = 1; stall_left = 3;
      do_read(C0);
      do_read(C0 ^ 34'h0C);
      gap_mode = 0;

      // R10 invalidate all
      @(negedge clk);
      inval_all = 1; req_valid = 1; req_we = 0; req_addr = C0;
      #1;
      chk(!req_ready, "R10 no accept during invalidate", req_ready, 0);
      @(negedge clk);
      inval_all = 0; req_valid = 0;
      for (int i = 0; i < 256; i++) mv[i] = 0;
      do_read(C0);                            // R10 previously cached line misses
      do_read(A0);                            // R10

      // R3 every word of a new line
      for (int w = 0; w < 8; w++) do_read(34'h3_0000_0400 + 34'(4 * w));

      // mixed sweep
      for (int i = 0; i < 40; i++) begin
         logic [33:0] a;
         a = {4'(i % 3), 30'(i * 32'h0001_3A64 + 32'h40)};
         if (i % 5 == 2) do_write(a, 32'(i * 32'h0101_0303), 4'(i % 16));
         else do_read(a);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule